// File: doc/BRIEF.md
# Debug Console Byte-Stream Port

This block is a bus-slave peripheral that carries a byte stream in both directions between a processor and an external debug host. The processor sees two 32-bit registers on a simple memory-mapped bus. One is a data register: reading it pops a received byte, and writing it queues a byte for transmission. The other is a control register that holds the interrupt enables, the pending flags, a host-activity flag and the free space in the transmit queue. The host side is a pair of plain valid/ready byte ports. The receive queue is filled from one port and the transmit queue is drained to the other.

A single data-register read returns three things together: the oldest received byte, a flag saying whether that byte is real, and how many bytes remain behind it. The read also consumes the byte. Software cannot peek at the next byte without taking it, so a driver must hold on to any byte it reads. The activity flag is sticky. It sets on every host-side transfer and is cleared by software, so a driver can clear it, wait, and read it again to judge whether a host is attached before it blocks on a full transmit queue. One level interrupt output combines the two pending conditions with their enables.

The bus is single-cycle. A select with a write strobe and a one-bit word address (byte offset bit 2) makes one access, and read data appears on the port one clock after the select.

Top module: `dbg_console_port`

## Requirements
- R1: After reset both queues are empty, both interrupt enables and the activity flag are 0, read data is 0 and the interrupt output is low, so a control read returns free space DEPTH in bits 31:16 with only bit 9 set below them.
- R2: A data read (word address 0) returns the byte in bits 7:0 and the valid flag in bit 15, with bits 14:8 always 0; the result is on the read-data port one clock after the select.
- R3: Bits 31:16 of a data read hold the number of bytes still waiting in the receive queue, not counting the byte returned by that read.
- R4: A data read with the valid flag set removes that byte from the receive queue; a data read of an empty queue returns 0 in every bit and changes nothing.
- R5: A data write pushes bits 7:0 into the transmit queue, and the host transmit port presents the bytes in the order written, with valid high while the queue is not empty.
- R6: Bits 31:16 of a control read hold DEPTH minus the transmit-queue fill; a data write to a full transmit queue is dropped and never reaches the host.
- R7: The host receive port drives ready low exactly while the receive queue holds DEPTH bytes, and accepted bytes are read back in arrival order.
- R8: Control writes (word address 1) load the read-interrupt enable from bit 0 and the write-interrupt enable from bit 1, and these read back in the same bits; bits 7:2 and 15:11 read as 0.
- R9: Control bit 10 (activity) becomes 1 after any accepted host-side transfer on either port; a control write with bit 10 set clears it, and a control write with bit 10 clear leaves it unchanged.
- R10: Control bit 8 (read pending) is 1 while the receive queue is not empty, and bit 9 (write pending) is 1 while the transmit queue has free space.
- R11: The interrupt output is high one clock after a state in which (bit 0 and bit 8) or (bit 1 and bit 9) hold, and low one clock after neither does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_word | input | 1 | 0 selects the data register (0x0), 1 selects the control register (0x4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid one cycle after the read select |
| host_rx_data | input | 8 | Byte from the host into the receive queue |
| host_rx_valid | input | 1 | Host offers a byte |
| host_rx_ready | output | 1 | Receive queue can accept a byte |
| host_tx_data | output | 8 | Oldest byte of the transmit queue |
| host_tx_valid | output | 1 | Transmit queue is not empty |
| host_tx_ready | input | 1 | Host takes the presented byte |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with DEPTH set to 8 instead of 64. At that depth both queues can be filled to the brim and run past it within a few dozen bus cycles. The bench then sweeps every fill level from one to full, pushing a burst of host bytes and draining it through data reads, and computes each returned word arithmetically from the level. This covers the full-queue ready drop, dropped transmit writes, a zero free-space field, the count-excludes-current rule at every level and the empty-read case.

// File: rtl/dbgc_pkg.sv
`timescale 1ns/1ps
package dbgc_pkg;
  // control register bit positions, software-visible
  localparam int unsigned CB_RIE = 0;
  localparam int unsigned CB_WIE = 1;
  localparam int unsigned CB_RIP = 8;
  localparam int unsigned CB_WIP = 9;
  localparam int unsigned CB_ACT = 10;
  // data register bit positions
  localparam int unsigned DB_VALID = 15;
  localparam int unsigned CNT_LSB = 16;
  localparam int unsigned CNT_W = 16;

  typedef struct packed {
    logic act;
    logic wie;
    logic rie;
  } ctl_state_t;
endpackage

// File: rtl/dbgc_fifo.sv
`timescale 1ns/1ps
module dbgc_fifo #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [$clog2(DEPTH):0] count,
  output logic             full,
  output logic             empty
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH) + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cnt;
  logic             do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];
  assign count   = cnt;

  // storage without reset so it maps onto RAM primitives
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R7: fill never exceeds the depth
  p_fill_bound_r7: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  // R6: a push into a full queue without a pop leaves it untouched
  p_full_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> ($stable(cnt) && $stable(wr_ptr)));

  // R4: a lone pop of a non-empty queue lowers the fill by one
  p_pop_dec_r4: assert property (@(posedge clk) disable iff (rst)
    (pop && !empty && !(push && !full)) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/dbgc_ctrl.sv
`timescale 1ns/1ps
module dbgc_ctrl
  import dbgc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ctl_wr,
  input  logic       wr_rie,
  input  logic       wr_wie,
  input  logic       wr_act_clr,
  input  logic       host_access,
  input  logic       rx_nonempty,
  input  logic       tx_has_space,
  output ctl_state_t ctl,
  output logic       irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl <= '0;
      irq <= 1'b0;
    end else begin
      if (ctl_wr) begin
        ctl.rie <= wr_rie;
        ctl.wie <= wr_wie;
      end
      // a host transfer in the clearing cycle wins, so no activity is lost
      if (host_access)              ctl.act <= 1'b1;
      else if (ctl_wr && wr_act_clr) ctl.act <= 1'b0;
      irq <= (ctl.rie && rx_nonempty) || (ctl.wie && tx_has_space);
    end
  end

  // R9: any host transfer leaves the activity flag set
  p_act_set_r9: assert property (@(posedge clk) disable iff (rst)
    host_access |=> ctl.act);

  // R11: the interrupt never rises without an enable in the cycle before
  p_irq_enable_r11: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ctl.rie || ctl.wie));
endmodule

// File: rtl/dbg_console_port.sv
`timescale 1ns/1ps
module dbg_console_port
  import dbgc_pkg::*;
#(
  parameter int unsigned DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic        bus_word,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [7:0]  host_rx_data,
  input  logic        host_rx_valid,
  output logic        host_rx_ready,
  output logic [7:0]  host_tx_data,
  output logic        host_tx_valid,
  input  logic        host_tx_ready,
  output logic        irq
);
  localparam int unsigned CW = $clog2(DEPTH) + 1;

  logic          rd_data, wr_data, rd_ctl, wr_ctl;
  logic [7:0]    rx_dout;
  logic [CW-1:0] rx_cnt, tx_cnt;
  logic          rx_full, rx_empty, tx_full, tx_empty;
  logic          host_access;
  ctl_state_t    ctl;
  logic [CNT_W-1:0] rx_left, tx_free;
  logic          unused_wbits;

  assign rd_data = bus_sel && !bus_wr && !bus_word;
  assign wr_data = bus_sel &&  bus_wr && !bus_word;
  assign rd_ctl  = bus_sel && !bus_wr &&  bus_word;
  assign wr_ctl  = bus_sel &&  bus_wr &&  bus_word;
  assign unused_wbits = ^{bus_wdata[31:11], bus_wdata[9:8], bus_wdata[7:2]};

  dbgc_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_rx_q (
    .clk(clk), .rst(rst),
    .push(host_rx_valid), .din(host_rx_data),
    .pop(rd_data), .dout(rx_dout),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  dbgc_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_tx_q (
    .clk(clk), .rst(rst),
    .push(wr_data), .din(bus_wdata[7:0]),
    .pop(host_tx_ready), .dout(host_tx_data),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  assign host_rx_ready = !rx_full;
  assign host_tx_valid = !tx_empty;
  assign host_access   = (host_rx_valid && !rx_full) || (host_tx_ready && !tx_empty);
  assign rx_left       = rx_empty ? '0 : CNT_W'(rx_cnt) - 1'b1;
  assign tx_free       = CNT_W'(DEPTH) - CNT_W'(tx_cnt);

  dbgc_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .ctl_wr(wr_ctl),
    .wr_rie(bus_wdata[CB_RIE]), .wr_wie(bus_wdata[CB_WIE]),
    .wr_act_clr(bus_wdata[CB_ACT]),
    .host_access(host_access),
    .rx_nonempty(!rx_empty), .tx_has_space(!tx_full),
    .ctl(ctl), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_data) begin
      bus_rdata <= '0;
      if (!rx_empty) begin
        bus_rdata[7:0]                   <= rx_dout;
        bus_rdata[DB_VALID]              <= 1'b1;
        bus_rdata[CNT_LSB +: CNT_W]      <= rx_left;
      end
    end else if (rd_ctl) begin
      bus_rdata <= '0;
      bus_rdata[CB_RIE]                  <= ctl.rie;
      bus_rdata[CB_WIE]                  <= ctl.wie;
      bus_rdata[CB_RIP]                  <= !rx_empty;
      bus_rdata[CB_WIP]                  <= !tx_full;
      bus_rdata[CB_ACT]                  <= ctl.act;
      bus_rdata[CNT_LSB +: CNT_W]        <= tx_free;
    end
  end

  // R2: reserved data bits are zero on every data read
  p_resv_zero_r2: assert property (@(posedge clk) disable iff (rst)
    rd_data |=> (bus_rdata[14:8] == 7'd0));

  // R4: reading an empty receive queue returns an all-zero word
  p_empty_read_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_data && rx_empty) |=> (bus_rdata == 32'd0));

  // R7: the host cannot be told ready while the receive queue is full
  p_rx_ready_r7: assert property (@(posedge clk) disable iff (rst)
    rx_full |-> !host_rx_ready);
endmodule

// File: tb/test_dbg_console_port.sv
`timescale 1ns/1ps
module test_dbg_console_port;
  localparam int unsigned D = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_word = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  host_rx_data = '0;
  logic        host_rx_valid = 1'b0;
  logic        host_rx_ready;
  logic [7:0]  host_tx_data;
  logic        host_tx_valid;
  logic        host_tx_ready = 1'b0;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  dbg_console_port #(.DEPTH(D)) i_dbg_console_port (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .host_rx_data(host_rx_data), .host_rx_valid(host_rx_valid),
    .host_rx_ready(host_rx_ready),
    .host_tx_data(host_tx_data), .host_tx_valid(host_tx_valid),
    .host_tx_ready(host_tx_ready), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic word, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_word = word; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bread(input logic word, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_word = word;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic hsend(input logic [7:0] b);
    @(negedge clk);
    host_rx_data = b; host_rx_valid = 1'b1;
    @(negedge clk);
    host_rx_valid = 1'b0;
  endtask

  task automatic htake(output logic v, output logic [7:0] b);
    @(negedge clk);
    v = host_tx_valid; b = host_tx_data;
    host_tx_ready = 1'b1;
    @(negedge clk);
    host_tx_ready = 1'b0;
  endtask

  function automatic logic [31:0] dword(input int left, input logic [7:0] b);
    return {16'(left), 1'b1, 7'd0, b};
  endfunction

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #400000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    logic        v;
    logic [7:0]  b;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 rdata", bus_rdata, 32'd0);
    bread(1'b1, r);
    chk("R1/R10 ctl", r, {16'(D), 16'h0200});
    bread(1'b0, r);
    chk("R1 empty data", r, 32'd0);

    // R8/R11 write enable with space -> irq
    bwrite(1'b1, 32'hFFFF_FBFE & 32'h0000_0002 | 32'hFFFF_F8FC);
    bread(1'b1, r);
    chk("R8 ctl wie", r, {16'(D), 16'h0202});
    repeat (2) @(negedge clk);
    chk("R11 irq wie", {31'd0, irq}, 32'd1);
    bwrite(1'b1, 32'd0);
    repeat (2) @(negedge clk);
    chk("R11 irq off", {31'd0, irq}, 32'd0);

    // R7 fill receive queue from host
    for (int i = 0; i < D; i++) begin
      chk("R7 ready", {31'd0, host_rx_ready}, 32'd1);
      hsend(8'(i * 37 + 5));
    end
    @(negedge clk);
    chk("R7 full ready low", {31'd0, host_rx_ready}, 32'd0);
    bread(1'b1, r);
    chk("R9/R10 ctl act ri", r, {16'(D), 16'h0700});
    bwrite(1'b1, 32'h0000_0401);
    bread(1'b1, r);
    chk("R9 act cleared", r, {16'(D), 16'h0301});
    repeat (2) @(negedge clk);
    chk("R11 irq rie", {31'd0, irq}, 32'd1);

    // R2 R3 R4 drain by data reads
    for (int i = 0; i < D; i++) begin
      bread(1'b0, r);
      chk("R2/R3 data", r, dword(D - 1 - i, 8'(i * 37 + 5)));
    end
    chk("R7 ready after drain", {31'd0, host_rx_ready}, 32'd1);
    repeat (2) @(negedge clk);
    chk("R11 irq drop", {31'd0, irq}, 32'd0);
    bread(1'b0, r);
    chk("R4 empty read", r, 32'd0);
    bread(1'b1, r);
    chk("R10 ri clear", r, {16'(D), 16'h0201});
    bwrite(1'b1, 32'd0);

    // R5 R6 transmit past full
    for (int i = 0; i < D + 2; i++) begin
      bwrite(1'b0, {24'hABCDEF, 8'(i * 11 + 3)});
      bread(1'b1, r);
      chk("R6 free", r, {16'((i + 1 >= D) ? 0 : D - i - 1),
                         (i + 1 >= D) ? 16'h0000 : 16'h0200});
    end
    for (int i = 0; i < D; i++) begin
      htake(v, b);
      chk("R5 tx order", {23'd0, v, b}, {23'd0, 1'b1, 8'(i * 11 + 3)});
    end
    @(negedge clk);
    chk("R6 dropped absent", {31'd0, host_tx_valid}, 32'd0);
    bwrite(1'b1, 32'h0000_0003);
    bread(1'b1, r);
    chk("R9 act kept", r, {16'(D), 16'h0603});
    bwrite(1'b1, 32'h0000_0400);
    bread(1'b1, r);
    chk("R9 act clear2", r, {16'(D), 16'h0200});

    // R3 sweep over every fill level
    for (int k = 1; k <= D; k++) begin
      for (int j = 0; j < k; j++) hsend(8'(k * 16 + j));
      for (int j = 0; j < k; j++) begin
        bread(1'b0, r);
        chk("R3 sweep", r, dword(k - 1 - j, 8'(k * 16 + j)));
      end
      bread(1'b0, r);
      chk("R4 sweep empty", r, 32'd0);
    end

    finish_run();
  end
endmodule